// File: doc/BRIEF.md
# Keyed Watchdog Timer with Masked Reset Pulse

This block is a watchdog peripheral behind a plain word-addressed read/write port. Software programs a reload value and restarts the 32-bit down-counter by writing one fixed key word. It then starts the timer by setting the enable bit in the control word. The counter steps either on every clock or on a slow tick made by an internal prescaler, which divides the clock by `TICK_DIV` to give 1 MHz at the nominal clock.

When the enabled counter sits at zero, the timer has expired. The block then drops its enable bit, raises a sticky timeout flag, and records the second-boot selection bit next to that flag. If resets are allowed, it also fires a reset pulse of programmable length. The pulse carries a latched two-bit reset class, 0 for the SoC, 1 for the whole chip, 2 for the CPU and 3 reserved, which is passed out unchanged. A per-subsystem mask gates the pulse onto 26 separate reset lines. Distributing these resets to the subsystems is left to the surrounding chip.

Top module: `wdog_top`

## Requirements
- R1: After reset every register reads 0 except the mask at word 7, which reads 0x03FFFFFF, and `timeout_flag`, `boot_flag`, `sys_rst`, `sub_rst` and `rst_mode` are all 0.
- R2: A write of exactly 0x00004755 to word 2 loads the counter from the reload value at word 1, and the counter status at word 0 shows the new value from the next cycle. A write of any other value to word 2 changes nothing. Word 2 reads 0.
- R3: While control bit 0 (enable) is set and control bit 4 is clear, the counter falls by one on each clock until it reaches 0. While enable is clear, the counter holds its value.
- R4: While control bit 4 is set, the enabled counter falls by one only once every `TICK_DIV` clocks.
- R5: When enable is set and the counter is 0, the block expires, and in the next cycle the enable bit reads back as 0. A control write made in that same cycle takes precedence.
- R6: On expiry, word 4 bit 0 (`timeout_flag`) goes to 1 and word 4 bit 1 (`boot_flag`) takes the value of control bit 7. A write to word 5 with bit 0 set clears both flags. If that write falls in the same cycle as an expiry, the expiry wins.
- R7: On expiry with control bit 1 set, `sys_rst` goes high in the next cycle and stays high for N cycles. N is the value held in the low 16 bits of word 6, or 1 when that value is 0.
- R8: `sub_rst[i]` equals `sys_rst` ANDed with bit i of the mask at word 7, for i = 0 to 25.
- R9: `rst_mode` shows the value of control bits 6:5 as captured at the last expiry that produced a pulse.
- R10: Control bits 0, 1, 4, 5, 6 and 7 are stored and read back at word 3, and every other control bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | 3 | Word index used for both reads and writes |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data of the word at `addr` |
| timeout_flag | output | 1 | Sticky expiry flag |
| boot_flag | output | 1 | Second-boot bit captured at expiry |
| sys_rst | output | 1 | System reset pulse |
| rst_mode | output | 2 | Reset class latched at expiry |
| sub_rst | output | 26 | Reset pulse gated per subsystem by the mask |

## Verification
The bound checker watches the cycle-level rules on every clock. These cover the key write loading the counter, the counter never rising without a key write and holding while disabled or between slow ticks, expiry clearing enable and setting the flag, a permitted expiry starting the pulse, and the subsystem lines staying low outside a pulse. Only the bench scenarios can show the things that take history: the exact pulse length including the zero-width case, the mask pattern reaching the lines, the latched reset class and captured boot bit, the control readback filtering, and rejection of wrong key values. The scenarios also show the slow tick really stretching the expiry time.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_AW = 3;
  localparam int DATA_W = 32;

  localparam logic [REG_AW-1:0] A_COUNT  = 3'd0;
  localparam logic [REG_AW-1:0] A_RELOAD = 3'd1;
  localparam logic [REG_AW-1:0] A_KICK   = 3'd2;
  localparam logic [REG_AW-1:0] A_CTRL   = 3'd3;
  localparam logic [REG_AW-1:0] A_STAT   = 3'd4;
  localparam logic [REG_AW-1:0] A_CLEAR  = 3'd5;
  localparam logic [REG_AW-1:0] A_WIDTH  = 3'd6;
  localparam logic [REG_AW-1:0] A_MASK   = 3'd7;

  localparam logic [DATA_W-1:0] KICK_KEY = 32'h0000_4755;

  typedef struct packed {
    logic       boot2;
    logic [1:0] mode;
    logic       slow;
    logic       rst_en;
    logic       en;
  } ctrl_t;

  function automatic logic [DATA_W-1:0] ctrl_pack(ctrl_t c);
    return {24'd0, c.boot2, c.mode, c.slow, 2'b00, c.rst_en, c.en};
  endfunction

  function automatic ctrl_t ctrl_unpack(logic [DATA_W-1:0] d);
    ctrl_t c;
    c.en     = d[0];
    c.rst_en = d[1];
    c.slow   = d[4];
    c.mode   = d[6:5];
    c.boot2  = d[7];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] count_next(logic [DATA_W-1:0] c, logic step);
    return (step && (c != '0)) ? c - 1'b1 : c;
  endfunction

  function automatic logic [DATA_W-1:0] pulse_len(logic [DATA_W-1:0] w);
    return (w == '0) ? 32'd1 : w;
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int NSUB = 26,
  parameter int PW_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              expire,
  input  logic [DATA_W-1:0] cnt,
  output logic [DATA_W-1:0] rd_data,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] reload,
  output logic [PW_W-1:0]   width,
  output logic [NSUB-1:0]   mask,
  output logic              kick_hit,
  output logic              ctrl_wr,
  output logic              timeout_flag,
  output logic              boot_cap
);
  logic sel_reload, sel_width, sel_mask, clr_hit;

  assign sel_reload = wr_en && (addr == A_RELOAD);
  assign sel_width  = wr_en && (addr == A_WIDTH);
  assign sel_mask   = wr_en && (addr == A_MASK);
  assign ctrl_wr    = wr_en && (addr == A_CTRL);
  assign kick_hit   = wr_en && (addr == A_KICK) && (wr_data == KICK_KEY);
  assign clr_hit    = wr_en && (addr == A_CLEAR) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl         <= '0;
      reload       <= '0;
      width        <= '0;
      mask         <= '1;
      timeout_flag <= 1'b0;
      boot_cap     <= 1'b0;
    end else begin
      if (sel_reload) reload <= wr_data;
      if (sel_width)  width  <= wr_data[PW_W-1:0];
      if (sel_mask)   mask   <= wr_data[NSUB-1:0];
      if (expire)     ctrl.en <= 1'b0;
      if (ctrl_wr)    ctrl   <= ctrl_unpack(wr_data);
      if (expire) begin
        timeout_flag <= 1'b1;
        boot_cap     <= ctrl.boot2;
      end else if (clr_hit) begin
        timeout_flag <= 1'b0;
        boot_cap     <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      A_COUNT:  rd_data = cnt;
      A_RELOAD: rd_data = reload;
      A_CTRL:   rd_data = ctrl_pack(ctrl);
      A_STAT:   rd_data = {30'd0, boot_cap, timeout_flag};
      A_WIDTH:  rd_data = DATA_W'(width);
      A_MASK:   rd_data = DATA_W'(mask);
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int TICK_DIV = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              slow,
  input  logic              kick_hit,
  input  logic [DATA_W-1:0] reload,
  output logic [DATA_W-1:0] cnt,
  output logic              tick,
  output logic              expire
);
  localparam int PRE_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] pre_q;
  logic             step;

  assign tick   = (pre_q == PRE_LAST);
  assign step   = en && (slow ? tick : 1'b1);
  assign expire = en && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt   <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (kick_hit) cnt <= reload;
      else          cnt <= count_next(cnt, step);
    end
  end
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse
  import wdog_pkg::*;
#(
  parameter int NSUB = 26,
  parameter int PW_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            expire,
  input  logic            rst_en,
  input  logic [1:0]      mode,
  input  logic [PW_W-1:0] width,
  input  logic [NSUB-1:0] mask,
  output logic            sys_rst,
  output logic [1:0]      rst_mode,
  output logic [NSUB-1:0] sub_rst
);
  logic [PW_W-1:0] left_q;
  logic            fire;

  assign fire    = expire && rst_en;
  assign sys_rst = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q   <= '0;
      rst_mode <= '0;
    end else if (fire) begin
      left_q   <= PW_W'(pulse_len(DATA_W'(width)));
      rst_mode <= mode;
    end else if (sys_rst) begin
      left_q   <= left_q - 1'b1;
    end
  end

  for (genvar i = 0; i < NSUB; i++) begin : g_gate
    assign sub_rst[i] = sys_rst & mask[i];
  end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int NSUB     = 26,
  parameter int PW_W     = 16,
  parameter int TICK_DIV = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  output logic              timeout_flag,
  output logic              boot_flag,
  output logic              sys_rst,
  output logic [1:0]        rst_mode,
  output logic [NSUB-1:0]   sub_rst
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] reload, cnt;
  logic [PW_W-1:0]   width;
  logic [NSUB-1:0]   mask;
  logic              kick_hit, ctrl_wr, expire, tick;

  wdog_regs #(.NSUB(NSUB), .PW_W(PW_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .expire(expire), .cnt(cnt), .rd_data(rd_data), .ctrl(ctrl), .reload(reload),
    .width(width), .mask(mask), .kick_hit(kick_hit), .ctrl_wr(ctrl_wr),
    .timeout_flag(timeout_flag), .boot_cap(boot_flag)
  );

  wdog_counter #(.TICK_DIV(TICK_DIV)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(ctrl.en), .slow(ctrl.slow), .kick_hit(kick_hit),
    .reload(reload), .cnt(cnt), .tick(tick), .expire(expire)
  );

  wdog_pulse #(.NSUB(NSUB), .PW_W(PW_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .expire(expire), .rst_en(ctrl.rst_en), .mode(ctrl.mode),
    .width(width), .mask(mask), .sys_rst(sys_rst), .rst_mode(rst_mode), .sub_rst(sub_rst)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int NSUB = 26
) (
  input logic            clk,
  input logic            rst_n,
  input logic            kick_hit,
  input logic            ctrl_wr,
  input logic            expire,
  input logic            tick,
  input logic            en,
  input logic            slow,
  input logic            rst_en,
  input logic [31:0]     cnt,
  input logic [31:0]     reload,
  input logic            timeout_flag,
  input logic            sys_rst,
  input logic [NSUB-1:0] sub_rst
);
  a_r2_kick_loads: assert property (@(posedge clk) disable iff (!rst_n)
    kick_hit |=> (cnt == $past(reload)));

  a_r3_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !kick_hit) |=> $stable(cnt));

  a_r3_never_up: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !kick_hit) |=> (cnt <= $past(cnt)));

  a_r4_slow_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (en && slow && !tick && !kick_hit) |=> $stable(cnt));

  a_r5_expire_disables: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctrl_wr) |=> !en);

  a_r6_flag_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> timeout_flag);

  a_r7_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && rst_en) |=> sys_rst);

  a_r8_quiet_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst |-> (sub_rst == '0));
endmodule

bind wdog_top wdog_chk #(.NSUB(NSUB)) u_chk (
  .clk(clk), .rst_n(rst_n), .kick_hit(kick_hit), .ctrl_wr(ctrl_wr), .expire(expire),
  .tick(tick), .en(ctrl.en), .slow(ctrl.slow), .rst_en(ctrl.rst_en), .cnt(cnt),
  .reload(reload), .timeout_flag(timeout_flag), .sys_rst(sys_rst), .sub_rst(sub_rst)
);

// File: tb/sim_wdog_top.sv
`timescale 1ns/1ps
module sim_wdog_top;
  localparam int DIV = 250;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wr_data = 32'd0;
  logic [31:0] rd_data;
  logic        timeout_flag, boot_flag, sys_rst;
  logic [1:0]  rst_mode;
  logic [25:0] sub_rst;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wdog_top u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .timeout_flag(timeout_flag), .boot_flag(boot_flag),
    .sys_rst(sys_rst), .rst_mode(rst_mode), .sub_rst(sub_rst)
  );

  // behavioural reference state
  logic [31:0] m_cnt, m_reload;
  logic        m_en, m_rsten, m_slow, m_boot, m_flag, m_bcap;
  logic [1:0]  m_mode, m_lmode;
  logic [15:0] m_width;
  logic [25:0] m_mask;
  int          m_pre, m_left;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_reload = 0; m_en = 0; m_rsten = 0; m_slow = 0; m_boot = 0;
      m_flag = 0; m_bcap = 0; m_mode = 0; m_lmode = 0; m_width = 0;
      m_mask = 26'h3FFFFFF; m_pre = 0; m_left = 0;
    end else begin
      bit expd, stepd;
      expd  = m_en && (m_cnt == 0);
      stepd = m_en && (!m_slow || m_pre == DIV - 1);
      m_pre = (m_pre == DIV - 1) ? 0 : m_pre + 1;
      if (m_left > 0) m_left = m_left - 1;
      if (expd && m_rsten) begin
        m_left  = (m_width == 0) ? 1 : int'(m_width);
        m_lmode = m_mode;
      end
      if (expd) begin
        m_flag = 1; m_bcap = m_boot;
      end else if (wr_en && addr == 5 && wr_data[0]) begin
        m_flag = 0; m_bcap = 0;
      end
      if (wr_en && addr == 2 && wr_data == 32'h4755) m_cnt = m_reload;
      else if (stepd && m_cnt != 0) m_cnt = m_cnt - 1;
      if (expd) m_en = 0;
      if (wr_en) begin
        case (addr)
          3'd1: m_reload = wr_data;
          3'd3: begin
            m_en = wr_data[0]; m_rsten = wr_data[1]; m_slow = wr_data[4];
            m_mode = wr_data[6:5]; m_boot = wr_data[7];
          end
          3'd6: m_width = wr_data[15:0];
          3'd7: m_mask = wr_data[25:0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] m_read(logic [2:0] a);
    case (a)
      3'd0: return m_cnt;
      3'd1: return m_reload;
      3'd3: return {24'd0, m_boot, m_mode, m_slow, 2'b00, m_rsten, m_en};
      3'd4: return {30'd0, m_bcap, m_flag};
      3'd6: return {16'd0, m_width};
      3'd7: return {6'd0, m_mask};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] a);
    case (a)
      3'd0: return "R3";
      3'd1, 3'd2: return "R2";
      3'd3: return "R10";
      3'd4, 3'd5: return "R6";
      3'd6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=0x%08h expected=0x%08h at %0t", tag, got, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the reference model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic sr;
      sr = (m_left > 0);
      check(tag_of(addr), rd_data, m_read(addr));
      check("R6", {31'd0, timeout_flag}, {31'd0, m_flag});
      check("R6", {31'd0, boot_flag}, {31'd0, m_bcap});
      check("R7", {31'd0, sys_rst}, {31'd0, sr});
      check("R8", {6'd0, sub_rst}, {6'd0, (sr ? m_mask : 26'd0)});
      check("R9", {30'd0, rst_mode}, {30'd0, m_lmode});
    end
  end

  int pulse_cycles = 0;
  logic [25:0] sub_seen = '0;
  always @(negedge clk) begin
    if (sys_rst) pulse_cycles++;
    sub_seen |= sub_rst;
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rd_data;
  endtask

  task automatic summary();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1", v, (a == 7) ? 32'h03FF_FFFF : 32'd0);
    end
    check("R1", {29'd0, sys_rst, timeout_flag, boot_flag}, 32'd0);

    // R2: wrong key ignored, right key loads
    wr(3'd1, 32'd10);
    wr(3'd2, 32'h0000_1234);
    rd(3'd0, v); check("R2", v, 32'd0);
    wr(3'd2, 32'h0001_4755);
    rd(3'd0, v); check("R2", v, 32'd0);
    wr(3'd2, 32'h0000_4755);
    rd(3'd0, v); check("R2", v, 32'd10);

    // R10: control readback filtering
    wr(3'd3, 32'hFFFF_FF0C);
    rd(3'd3, v); check("R10", v, 32'd0);
    wr(3'd3, 32'h0000_00B0);
    rd(3'd3, v); check("R10", v, 32'h0000_00B0);
    wr(3'd3, 32'd0);

    // R3: hold while disabled
    repeat (5) @(posedge clk);
    rd(3'd0, v); check("R3", v, 32'd10);

    // R3: count each clock
    wr(3'd3, 32'h0000_0001);
    repeat (4) @(posedge clk);
    rd(3'd0, v); check("R3", v, 32'd6);

    // R5/R6: expiry without reset permission
    pulse_cycles = 0;
    repeat (20) @(posedge clk);
    rd(3'd3, v); check("R5", v, 32'd0);
    rd(3'd4, v); check("R6", v, 32'd1);
    check("R7", pulse_cycles, 0);

    // R6: clear needs bit 0
    wr(3'd5, 32'h0000_0002);
    rd(3'd4, v); check("R6", v, 32'd1);
    wr(3'd5, 32'h0000_0001);
    rd(3'd4, v); check("R6", v, 32'd0);

    // R7/R8/R9: masked reset pulse of width 3, class 2, boot bit set
    wr(3'd6, 32'd3);
    wr(3'd7, 32'h0000_0005);
    wr(3'd1, 32'd2);
    wr(3'd2, 32'h0000_4755);
    pulse_cycles = 0; sub_seen = '0;
    wr(3'd3, 32'h0000_00C3);
    repeat (20) @(posedge clk);
    check("R7", pulse_cycles, 3);
    check("R8", {6'd0, sub_seen}, 32'h0000_0005);
    check("R9", {30'd0, rst_mode}, 32'd2);
    rd(3'd4, v); check("R6", v, 32'd3);

    // R7: zero width gives one cycle, reload of 1 expires quickly
    wr(3'd5, 32'd1);
    wr(3'd6, 32'd0);
    wr(3'd7, 32'h03FF_FFFF);
    wr(3'd1, 32'd1);
    wr(3'd2, 32'h0000_4755);
    pulse_cycles = 0; sub_seen = '0;
    wr(3'd3, 32'h0000_0003);
    repeat (6) @(posedge clk);
    check("R7", pulse_cycles, 1);
    check("R8", {6'd0, sub_seen}, 32'h03FF_FFFF);
    check("R9", {30'd0, rst_mode}, 32'd0);
    rd(3'd3, v); check("R5", v, 32'd2);

    // R4: slow tick stretches counting
    wr(3'd5, 32'd1);
    wr(3'd1, 32'd3);
    wr(3'd2, 32'h0000_4755);
    wr(3'd3, 32'h0000_0011);
    repeat (100) @(posedge clk);
    rd(3'd0, v); check("R4", {31'd0, (v >= 32'd2)}, 32'd1);
    rd(3'd4, v); check("R4", v, 32'd0);
    repeat (4 * DIV + 20) @(posedge clk);
    rd(3'd4, v); check("R4", v, 32'd1);

    repeat (2) @(negedge clk);
    summary();
  end
endmodule